// File: doc/BRIEF.md
# Multi-Source XOR Descriptor Executor

This block runs one 128-byte work descriptor against a word-addressed memory port. Before it starts, the descriptor is written into a local buffer of 32 words. A start pulse then latches the decoded control word, and the block carries out one of three operations: a no-op, a copy, or an XOR of one to eight source buffers into one destination buffer. Source addresses for the XOR are 48-bit byte addresses. They are packed so that each pair of sources shares three descriptor words.

For each word offset, the block reads every active source in index order, folds the values into an accumulator, and writes the result to the destination once. At the end it rewrites the flag half of descriptor word 0 and raises a one-cycle done pulse. If the descriptor requested an interrupt, an interrupt pulse is raised alongside it. Word 0 can always be observed on `stat_word`. The memory port has a fixed read latency of one cycle: data requested while `mem_rd` is high must be on `mem_rdata` in the following cycle. Addresses on the port are word addresses, which are byte address bits [47:2].

Top module: `xor_desc_exec`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `mem_rd` and `mem_wr` are low and `stat_word` is zero.
- R2: A descriptor word write (`dsc_we`, `dsc_idx`, `dsc_wdata`) takes effect only while `busy` is low. A write made while busy leaves the buffer unchanged, and this can be observed through word 0 on `stat_word`.
- R3: The operation code is control word (word 2) bits [31:28]. Code 0 is a no-op, 1 is a copy and 6 is an XOR. Any other code sets the error flag and the block makes no memory access.
- R4: A no-op accepted at a clock edge gives `done` two edges later. It makes no memory access, and `irq` goes high with `done` when control bit 27 is set.
- R5: A copy takes its source address from words 4 (low 32 bits) and 5 (bits [15:0] = high 16 bits), and its destination from words 6 and 7 in the same layout. Each destination word equals the source word at the same offset.
- R6: An XOR uses control bits [25:22] as the source count. Source pair p starts at word 8+3p. That word is the even source's low 32 bits, the next word is the odd source's low 32 bits, and the third word carries the even source's high 16 bits in [15:0] and the odd source's high 16 bits in [31:16]. Each destination word is the XOR of all active sources at that offset.
- R7: An XOR whose source count is 0 or greater than 8 sets the error flag and the block makes no memory access.
- R8: Word 3 is the byte count. For a copy or XOR, a count that is not a multiple of 4 sets the error flag and the block makes no memory access. A count of 0 completes without error and without access.
- R9: An XOR with control bit 17 (parity destination enable) clear makes no memory access and completes without error.
- R10: Each destination word is written exactly once, in ascending address order, after all of its source reads. A run makes exactly count/4 × sources reads. Reads and writes never occur in the same cycle.
- R11: At completion, word 0 keeps its identifier in [15:0]. Bit 16 is set (done), bit 17 holds the error flag, and bits [31:18] are cleared. `done` is a one-cycle pulse, and `irq` is only ever high together with `done`.
- R12: A start pulse while `busy` is high is ignored. The run in progress makes no extra accesses and no second completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsc_we | input | 1 | Descriptor buffer write strobe |
| dsc_idx | input | 5 | Descriptor word index |
| dsc_wdata | input | 32 | Descriptor word value |
| start | input | 1 | Begin executing the buffered descriptor |
| busy | output | 1 | A descriptor is being executed |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request pulse, with done |
| stat_word | output | 32 | Current contents of descriptor word 0 |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 46 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |

## Verification
The assertions assume that memory answers every read in the very next cycle. They also assume that the descriptor buffer is written only between runs, because the source table and destination address are read live from it during a run. The bench provides a memory model with exactly that one-cycle latency. It loads every descriptor only while `busy` is low, except in the single case that deliberately tests the ignored write. Source buffers are given distinct high address halves, so a wrongly unpacked high field lands on a different region and shows up as a wrong result.

// File: rtl/xdx_pkg.sv
package xdx_pkg;

  localparam int BYTE_AW    = 48;
  localparam int WAW        = BYTE_AW - 2;
  localparam int DESC_WORDS = 32;
  localparam int LEN_W      = 30;
  localparam int CNT_W      = 4;

  localparam logic [3:0] OPC_NOP  = 4'd0;
  localparam logic [3:0] OPC_COPY = 4'd1;
  localparam logic [3:0] OPC_XOR  = 4'd6;

  typedef enum logic [1:0] {K_NOP, K_COPY, K_XOR, K_BAD} op_kind_e;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_ACC, S_WR, S_FIN} st_e;

  typedef struct packed {
    op_kind_e           kind;
    logic [CNT_W-1:0]   nsrc;
    logic [LEN_W-1:0]   nwords;
    logic               err;
    logic               irq_req;
    logic               skip;
  } dec_t;

  // byte address {hi16, lo32} reduced to a word address
  function automatic logic [WAW-1:0] f_word_addr(input logic [15:0] hi,
                                                 input logic [31:0] lo);
    logic [BYTE_AW-1:0] b;
    b = {hi, lo};
    return b[BYTE_AW-1:2];
  endfunction

  // first descriptor word of the packed group holding source k
  function automatic int f_group_base(input int k);
    return 8 + 3 * (k / 2);
  endfunction

  function automatic logic f_len_bad(input logic [31:0] bytes);
    return bytes[1:0] != 2'b00;
  endfunction

  // completion status: identifier kept, done bit set, error recorded
  function automatic logic [31:0] f_status(input logic [15:0] id,
                                           input logic err);
    return {14'b0, err, 1'b1, id};
  endfunction

endpackage

// File: rtl/xdx_decode.sv
module xdx_decode
  import xdx_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic [3:0]       opc,
  input  logic             irq_bit,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pen,
  input  logic [31:0]      bytes,
  output dec_t             dec
);

  logic bad_op, bad_cnt, bad_len, is_xor, is_copy, is_nop;

  always_comb begin
    is_nop  = (opc == OPC_NOP);
    is_copy = (opc == OPC_COPY);
    is_xor  = (opc == OPC_XOR);
    bad_op  = !(is_nop || is_copy || is_xor);
    bad_cnt = is_xor && ((cnt == '0) || (int'(cnt) > NS));
    bad_len = (is_copy || is_xor) && f_len_bad(bytes);

    dec.kind    = bad_op ? K_BAD : (is_copy ? K_COPY : (is_xor ? K_XOR : K_NOP));
    dec.nsrc    = is_copy ? CNT_W'(1) : cnt;
    dec.nwords  = bytes[31:2];
    dec.err     = bad_op || bad_cnt || bad_len;
    dec.irq_req = irq_bit;
    dec.skip    = dec.err || is_nop || (is_xor && !pen) || (bytes[31:2] == '0);
  end

endmodule

// File: rtl/xdx_src_unpack.sv
module xdx_src_unpack
  import xdx_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic [31:0]    w [DESC_WORDS],
  output logic [WAW-1:0] addr [NS]
);

  for (genvar k = 0; k < NS; k++) begin : g_src
    localparam int B = f_group_base(k);
    if ((k % 2) == 0) begin : g_even
      assign addr[k] = f_word_addr(w[B+2][15:0], w[B]);
    end else begin : g_odd
      assign addr[k] = f_word_addr(w[B+2][31:16], w[B+1]);
    end
  end

endmodule

// File: rtl/xdx_engine.sv
module xdx_engine
  import xdx_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  dec_t           dec,
  input  logic [WAW-1:0] src_tab [NS],
  input  logic [WAW-1:0] dst_addr,
  output logic           busy,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [WAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  output logic           done,
  output logic           irq,
  output logic           fin_evt,
  output logic           err_q
);

  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  st_e              state;
  logic [CNT_W-1:0] scnt, nsrc_q;
  logic [LEN_W-1:0] wcnt, nwords_q;
  logic [31:0]      acc;
  logic             irq_q;

  logic accept, last_src, last_word, acc_done_evt;

  assign accept       = (state == S_IDLE) && start;
  assign last_src     = (scnt == nsrc_q - CNT_W'(1));
  assign last_word    = (wcnt == nwords_q - LEN_W'(1));
  assign acc_done_evt = (state == S_ACC) && last_src;
  assign fin_evt      = (state == S_FIN);
  assign busy         = (state != S_IDLE);
  assign mem_rd       = (state == S_RD);
  assign mem_wr       = (state == S_WR);
  assign mem_wdata    = acc;

  always_comb begin
    mem_addr = '0;
    case (state)
      S_RD:    mem_addr = src_tab[scnt[IW-1:0]] + WAW'(wcnt);
      S_WR:    mem_addr = dst_addr + WAW'(wcnt);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      scnt     <= '0;
      wcnt     <= '0;
      nsrc_q   <= '0;
      nwords_q <= '0;
      acc      <= '0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      done <= 1'b0;
      irq  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          nsrc_q   <= dec.nsrc;
          nwords_q <= dec.nwords;
          err_q    <= dec.err;
          irq_q    <= dec.irq_req;
          scnt     <= '0;
          wcnt     <= '0;
          state    <= dec.skip ? S_FIN : S_RD;
        end
        S_RD: state <= S_ACC;
        S_ACC: begin
          acc <= (scnt == '0) ? mem_rdata : (acc ^ mem_rdata);
          if (last_src) state <= S_WR;
          else begin
            scnt  <= scnt + CNT_W'(1);
            state <= S_RD;
          end
        end
        S_WR: begin
          scnt <= '0;
          if (last_word) state <= S_FIN;
          else begin
            wcnt  <= wcnt + LEN_W'(1);
            state <= S_RD;
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          irq   <= irq_q;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  wr_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(acc_done_evt));

  // R10
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R3
  err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_q) |-> !(mem_rd || mem_wr));

  // R12
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_evt && start) |=> busy);

endmodule

// File: rtl/xor_desc_exec.sv
module xor_desc_exec
  import xdx_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dsc_we,
  input  logic [4:0]     dsc_idx,
  input  logic [31:0]    dsc_wdata,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           irq,
  output logic [31:0]    stat_word,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [WAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata
);

  logic [31:0]    dsc [DESC_WORDS];
  dec_t           dec;
  logic [WAW-1:0] packed_src [NS];
  logic [WAW-1:0] src_tab [NS];
  logic [WAW-1:0] copy_src, dst_addr;
  logic           fin_evt, err_q, load_ok;

  assign load_ok   = dsc_we && !busy;
  assign stat_word = dsc[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DESC_WORDS; i++) dsc[i] <= '0;
    end else if (fin_evt) begin
      dsc[0] <= f_status(dsc[0][15:0], err_q);
    end else if (load_ok) begin
      dsc[dsc_idx] <= dsc_wdata;
    end
  end

  xdx_decode #(.NS(NS)) u_dec (
    .opc     (dsc[2][31:28]),
    .irq_bit (dsc[2][27]),
    .cnt     (dsc[2][25:22]),
    .pen     (dsc[2][17]),
    .bytes   (dsc[3]),
    .dec     (dec)
  );

  xdx_src_unpack #(.NS(NS)) u_unpack (
    .w    (dsc),
    .addr (packed_src)
  );

  assign copy_src = f_word_addr(dsc[5][15:0], dsc[4]);
  assign dst_addr = f_word_addr(dsc[7][15:0], dsc[6]);

  for (genvar k = 0; k < NS; k++) begin : g_tab
    if (k == 0) begin : g_first
      assign src_tab[k] = (dec.kind == K_COPY) ? copy_src : packed_src[k];
    end else begin : g_rest
      assign src_tab[k] = packed_src[k];
    end
  end

  xdx_engine #(.NS(NS)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dec       (dec),
    .src_tab   (src_tab),
    .dst_addr  (dst_addr),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .irq       (irq),
    .fin_evt   (fin_evt),
    .err_q     (err_q)
  );

  // R2
  frozen_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dsc[2]));

  // R11
  status_done_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stat_word[16]);

endmodule

// File: tb/tb_xor_desc_exec.sv
`timescale 1ns/1ps
module tb_xor_desc_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsc_we = 1'b0;
  logic [4:0]  dsc_idx = '0;
  logic [31:0] dsc_wdata = '0;
  logic        start = 1'b0;
  logic        busy, done, irq, mem_rd, mem_wr;
  logic [31:0] stat_word, mem_wdata;
  logic [31:0] mem_rdata;
  logic [45:0] mem_addr;

  always #2.5 clk = ~clk;

  xor_desc_exec dut (
    .clk(clk), .rst_n(rst_n), .dsc_we(dsc_we), .dsc_idx(dsc_idx),
    .dsc_wdata(dsc_wdata), .start(start), .busy(busy), .done(done),
    .irq(irq), .stat_word(stat_word), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  localparam int DSTW = 100;
  localparam logic [3:0] DSTH = 4'd9;

  function automatic logic [31:0] f_init(input int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [11:0] f_idx(input logic [45:0] a);
    return {a[33:30], a[7:0]};
  endfunction

  function automatic logic [45:0] f_waddr(input logic [3:0] hi, input int w);
    return {12'b0, hi, 22'b0, 8'(w)};
  endfunction

  // memory model: one-cycle read latency, initialised during reset
  logic [31:0] mem [4096];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          addr_bad = 0;
  int          order_bad = 0;
  logic [45:0] exp_wr_base = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] = f_init(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd || mem_wr) begin
        if (mem_addr[45:34] != 0 || mem_addr[29:8] != 0) addr_bad++;
      end
      if (mem_rd) begin
        mem_rdata <= mem[f_idx(mem_addr)];
        rd_cnt++;
      end
      if (mem_wr) begin
        mem[f_idx(mem_addr)] <= mem_wdata;
        if (mem_addr != exp_wr_base + 46'(wr_cnt)) order_bad++;
        wr_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int idx, input logic [31:0] v);
    @(negedge clk);
    dsc_we = 1'b1; dsc_idx = 5'(idx); dsc_wdata = v;
    @(negedge clk);
    dsc_we = 1'b0;
  endtask

  function automatic logic [31:0] f_ctrl(input logic [3:0] op, input bit irqb,
                                         input logic [3:0] cnt, input bit pen);
    return {op, irqb, 1'b0, cnt, 4'b0, pen, 17'b0};
  endfunction

  int lat;
  bit got_irq;

  task automatic run_desc();
    int t;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; got_irq = 1'b0; t = 0;
    while (!done && t < 4000) begin
      @(negedge clk);
      lat++; t++;
    end
    got_irq = irq;
    if (t >= 4000) chk(1'b0, "timeout", 32'(t), 32'd0);
  endtask

  function automatic int src_w(input int k);
    return 20 + 7 * k;
  endfunction

  task automatic load_srcs();
    for (int p = 0; p < 4; p++) begin
      wr_word(8 + 3*p, 32'(src_w(2*p)) << 2);
      wr_word(9 + 3*p, 32'(src_w(2*p+1)) << 2);
      wr_word(10 + 3*p, {16'(2*p+2), 16'(2*p+1)});
    end
  endtask

  task automatic load_dst();
    wr_word(6, 32'(DSTW) << 2);
    wr_word(7, 32'(DSTH));
  endtask

  // run a descriptor that must make no memory access
  task automatic run_quiet(input string req, input logic [31:0] ctrl,
                           input logic [31:0] bytes, input logic [15:0] id,
                           input bit exp_err);
    int r0, w0;
    wr_word(0, {16'hFFFF, id});
    wr_word(2, ctrl);
    wr_word(3, bytes);
    r0 = rd_cnt; w0 = wr_cnt;
    run_desc();
    chk((rd_cnt - r0) == 0 && (wr_cnt - w0) == 0, req, 32'(rd_cnt - r0 + wr_cnt - w0), 0);
    @(negedge clk);
    chk(stat_word == {14'b0, exp_err, 1'b1, id}, {req, " status"}, stat_word,
        {14'b0, exp_err, 1'b1, id});
  endtask

  task automatic run_xor(input int n, input int len, input bit irqb,
                         input logic [15:0] id);
    int r0, w0;
    logic [31:0] e, pre;
    wr_word(0, {16'hABCD, id});
    wr_word(2, f_ctrl(4'd6, irqb, 4'(n), 1'b1));
    wr_word(3, 32'(len * 4));
    pre = mem[{DSTH, 8'(DSTW + len)}];
    exp_wr_base = f_waddr(DSTH, DSTW) - 46'(wr_cnt);
    r0 = rd_cnt; w0 = wr_cnt;
    run_desc();
    // R10: read and write counts
    chk((rd_cnt - r0) == n * len, "R10 reads", 32'(rd_cnt - r0), 32'(n * len));
    chk((wr_cnt - w0) == len, "R10 writes", 32'(wr_cnt - w0), 32'(len));
    // R11: interrupt follows control bit 27
    chk(got_irq == irqb, "R11 irq", 32'(got_irq), 32'(irqb));
    @(negedge clk);
    chk(stat_word == {14'b0, 1'b0, 1'b1, id}, "R11 status", stat_word,
        {16'h0001, id});
    for (int j = 0; j < len; j++) begin
      e = '0;
      for (int k = 0; k < n; k++)
        e ^= f_init(int'({4'(k + 1), 8'(src_w(k) + j)}));
      chk(mem[{DSTH, 8'(DSTW + j)}] == e, "R6 xor data", mem[{DSTH, 8'(DSTW + j)}], e);
    end
    chk(mem[{DSTH, 8'(DSTW + len)}] == pre, "R10 beyond end", mem[{DSTH, 8'(DSTW + len)}], pre);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r0, w0;
    logic [31:0] e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !irq && !mem_rd && !mem_wr, "R1 idle outputs",
        {27'b0, busy, done, irq, mem_rd, mem_wr}, 0);
    chk(stat_word == 0, "R1 stat_word", stat_word, 0);

    // R4 no-op with interrupt: done two edges after acceptance
    wr_word(0, 32'h0000_1111);
    wr_word(2, f_ctrl(4'd0, 1'b1, 4'd0, 1'b0));
    wr_word(3, 32'd64);
    r0 = rd_cnt; w0 = wr_cnt;
    run_desc();
    chk(lat == 2, "R4 nop latency", 32'(lat), 2);
    chk(got_irq == 1'b1, "R4 nop irq", 32'(got_irq), 1);
    chk((rd_cnt - r0) + (wr_cnt - w0) == 0, "R4 nop no access", 32'(rd_cnt - r0), 0);
    @(negedge clk);
    chk(stat_word == 32'h0001_1111, "R11 nop status", stat_word, 32'h0001_1111);
    run_desc();
    chk(lat == 2 && got_irq == 1'b1, "R4 nop repeat", 32'(lat), 2);
    wr_word(2, f_ctrl(4'd0, 1'b0, 4'd0, 1'b0));
    run_desc();
    chk(got_irq == 1'b0, "R4 nop without irq", 32'(got_irq), 0);

    // R5 copy of 4 words
    wr_word(0, 32'h0000_2222);
    wr_word(4, 32'd200 << 2);
    wr_word(5, 32'h0000_000C);
    load_dst();
    wr_word(2, f_ctrl(4'd1, 1'b0, 4'd0, 1'b0));
    wr_word(3, 32'd16);
    exp_wr_base = f_waddr(DSTH, DSTW) - 46'(wr_cnt);
    r0 = rd_cnt; w0 = wr_cnt;
    run_desc();
    chk((rd_cnt - r0) == 4 && (wr_cnt - w0) == 4, "R5 copy counts",
        32'(rd_cnt - r0), 4);
    for (int j = 0; j < 4; j++) begin
      e = f_init(int'({4'd12, 8'(200 + j)}));
      chk(mem[{DSTH, 8'(DSTW + j)}] == e, "R5 copy data", mem[{DSTH, 8'(DSTW + j)}], e);
    end

    // R6 sweep over every legal source count
    load_srcs();
    for (int n = 1; n <= 8; n++) run_xor(n, 1 + (n % 3), n[0], 16'(16'h3000 + n));
    run_xor(8, 5, 1'b1, 16'h3999);

    // R7 illegal source counts
    run_quiet("R7 count zero", f_ctrl(4'd6, 1'b0, 4'd0, 1'b1), 32'd8, 16'h4000, 1'b1);
    run_quiet("R7 count nine", f_ctrl(4'd6, 1'b1, 4'd9, 1'b1), 32'd8, 16'h4001, 1'b1);
    // R8 byte count rules
    run_quiet("R8 unaligned xor", f_ctrl(4'd6, 1'b0, 4'd2, 1'b1), 32'd6, 16'h5000, 1'b1);
    run_quiet("R8 unaligned copy", f_ctrl(4'd1, 1'b0, 4'd0, 1'b0), 32'd3, 16'h5001, 1'b1);
    run_quiet("R8 zero length", f_ctrl(4'd6, 1'b0, 4'd3, 1'b1), 32'd0, 16'h5002, 1'b0);
    // R3 undefined operation codes
    run_quiet("R3 opcode 3", f_ctrl(4'd3, 1'b0, 4'd2, 1'b1), 32'd8, 16'h6000, 1'b1);
    run_quiet("R3 opcode 15", f_ctrl(4'd15, 1'b0, 4'd2, 1'b1), 32'd8, 16'h6001, 1'b1);
    // R9 parity destination disabled
    run_quiet("R9 no parity dest", f_ctrl(4'd6, 1'b0, 4'd4, 1'b0), 32'd8, 16'h7000, 1'b0);

    // R12 and R2: start and buffer write during a run
    wr_word(0, 32'h0000_8888);
    wr_word(2, f_ctrl(4'd6, 1'b0, 4'd8, 1'b1));
    wr_word(3, 32'd8);
    exp_wr_base = f_waddr(DSTH, DSTW) - 46'(wr_cnt);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; dsc_we = 1'b1; dsc_idx = 5'd0; dsc_wdata = 32'h0000_DEAD;
    @(negedge clk);
    start = 1'b0; dsc_we = 1'b0;
    begin
      int t = 0;
      while (!done && t < 4000) begin @(negedge clk); t++; end
    end
    @(negedge clk);
    repeat (10) begin
      chk(!done, "R12 no second completion", 32'(done), 0);
      @(negedge clk);
    end
    chk((rd_cnt - r0) == 16 && (wr_cnt - w0) == 2, "R12 single run",
        32'(rd_cnt - r0 + wr_cnt - w0), 18);
    chk(stat_word == 32'h0001_8888, "R2 write while busy ignored", stat_word,
        32'h0001_8888);

    // global address and ordering monitors
    chk(addr_bad == 0, "R6 high address unpack", 32'(addr_bad), 0);
    chk(order_bad == 0, "R10 write order", 32'(order_bad), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule